// File: doc/BRIEF.md
# Parallel Printer Port Host Register Interface

This block sits between a CPU register bus and the pins of a parallel printer port. It holds three byte registers at offsets 0, 1 and 2 from the port base. They are a data register, a status view and a control register. The data register drives the eight data pins. The control register drives the four active-low handshake outputs and two plain mode bits. The status view returns the five peripheral status inputs after they have been synchronized, with per-bit inversion where the bit definition requires it.

In EPP mode, the block also watches each bus cycle with a 10 µs timer. The timer's length in clocks is derived from the clock frequency parameter. If the peripheral does not answer within that window, a sticky timeout flag is set in status bit 0. Software clears the flag by writing a one to that bit.

All accesses are synchronous to `clk`. A write is a one-cycle `cpu_wr` pulse. A read is a level on `cpu_rd`, held for as long as the read cycle lasts, and `cpu_rdata` is combinational from the address.

Top module: `pport_regs`

## Requirements
- R1: After reset the data register is 0x00 and control bits 5:0 are 0. The pins then read `pd_out`=0x00, `strobe_n`=1, `autofd_n`=1, `init_n`=0, `selin_n`=1 and `pd_oe`=1, and the timeout flag is 0.
- R2: A write to offset 0 stores `cpu_wdata`, and from the next cycle `pd_out` carries it unchanged.
- R3: A read of offset 0 returns `pd_in` as it is at that moment when `epp_mode`=0, and the stored data register when `epp_mode`=1.
- R4: A read of offset 1 returns this byte from synchronized inputs: bit7 = NOT `busy`, bit6 = `ack_n`, bit5 = `pe`, bit4 = `slct`, bit3 = `err_n`, bits 2:1 = 0, bit0 = timeout flag. An input change is visible no more than 4 cycles after it occurs.
- R5: While `cpu_rd` stays high, the offset-1 value does not change, even if the inputs change.
- R6: A write to offset 2 stores `cpu_wdata[5:0]`. A read of offset 2 returns those bits with bits 7:6 as 0.
- R7: The control pins follow the register: `strobe_n` = NOT bit0, `autofd_n` = NOT bit1, `init_n` = bit2, `selin_n` = NOT bit3.
- R8: `pd_oe` is the inverse of control bit 5, which is the direction bit. Bit 4 is storage only.
- R9: With `epp_mode`=1, an `epp_start` pulse starts the timer. The flag sets exactly `CLK_HZ*TMO_NS/1e9` cycles after the start edge unless the synchronized `epp_rsp` arrives first, in which case the timer stops and the flag is not set.
- R10: A write to offset 1 with bit0=1 clears the flag in that single write. A write with bit0=0 leaves the flag as it was.
- R11: Offsets 3 and above read as 0x00, and writes to them change neither the data register nor the control register.
- R12: With `epp_mode`=0, `epp_start` does not start the timer, so the flag stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_addr | input | AW | Register offset from port base |
| cpu_wr | input | 1 | One-cycle write strobe |
| cpu_wdata | input | 8 | Write data |
| cpu_rd | input | 1 | Read cycle level; status is frozen while high |
| cpu_rdata | output | 8 | Read data for the addressed offset |
| epp_mode | input | 1 | 1 selects EPP mode, 0 standard mode |
| epp_start | input | 1 | Pulse marking the start of an EPP bus cycle |
| epp_rsp | input | 1 | Peripheral response to the EPP cycle (asynchronous) |
| pd_out | output | 8 | Data pin drive value |
| pd_oe | output | 1 | Data pin output enable |
| pd_in | input | 8 | Data pin levels |
| strobe_n | output | 1 | Active-low strobe |
| autofd_n | output | 1 | Active-low autofeed |
| init_n | output | 1 | Init output, non-inverted from control bit 2 |
| selin_n | output | 1 | Active-low select-in |
| busy | input | 1 | Peripheral busy (asynchronous) |
| ack_n | input | 1 | Peripheral acknowledge, active low (asynchronous) |
| pe | input | 1 | Paper end (asynchronous) |
| slct | input | 1 | Peripheral selected (asynchronous) |
| err_n | input | 1 | Peripheral error, active low (asynchronous) |

## Verification
The assertions assume that `cpu_wr` and `cpu_rd` are never high in the same cycle. They also assume that `cpu_rd` is low during reset and that `epp_start` is a single-cycle pulse. The bench drives every bus signal on the falling clock edge. It holds one access at a time and returns both strobes to low between accesses. The random phase draws offsets across all eight codes. It changes the status inputs only while `cpu_rd` is low, except in the directed freeze case. There, the inputs change deliberately in the middle of a read, and the frozen value is what gets checked.

// File: rtl/pport_pkg.sv
package pport_pkg;

  localparam int unsigned OFS_DATA = 0;
  localparam int unsigned OFS_STAT = 1;
  localparam int unsigned OFS_CTRL = 2;

  typedef struct packed {
    logic busy;
    logic ack_n;
    logic pe;
    logic slct;
    logic err_n;
  } pin_stat_t;

  // Number of clocks in a timeout window of ns nanoseconds.
  function automatic int unsigned tmo_cycles(longint unsigned clk_hz,
                                             longint unsigned ns);
    longint unsigned prod;
    prod = clk_hz * ns;
    return int'(prod / 64'd1_000_000_000);
  endfunction

  // Status byte assembled from the synchronized pins and the flag.
  function automatic logic [7:0] pack_status(pin_stat_t s, logic flag);
    return {~s.busy, s.ack_n, s.pe, s.slct, s.err_n, 2'b00, flag};
  endfunction

endpackage

// File: rtl/pport_sync.sv
module pport_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      q      <= '0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/pport_tmo.sv
module pport_tmo #(
  parameter int unsigned LIMIT = 500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic start,
  input  logic rsp,
  input  logic clr,
  output logic flag,
  output logic hit
);
  localparam int CW = $clog2(LIMIT + 1);

  logic          active_q;
  logic [CW-1:0] cnt_q;

  assign hit = active_q && !rsp && (cnt_q == CW'(LIMIT - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else if (!enable || hit) begin
      active_q <= 1'b0;
    end else if (start) begin
      active_q <= 1'b1;
      cnt_q    <= '0;
    end else if (active_q && rsp) begin
      active_q <= 1'b0;
    end else if (active_q) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   flag <= 1'b0;
    else if (hit) flag <= 1'b1;
    else if (clr) flag <= 1'b0;
  end

  assert_cnt_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    active_q |-> (cnt_q < CW'(LIMIT)));
  assert_hit_sets_R9: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> flag);
  assert_rsp_stops_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && rsp && !start) |=> !active_q);
  assert_spp_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !active_q);
  assert_clr_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !hit) |=> !flag);
endmodule

// File: rtl/pport_regs.sv
module pport_regs
  import pport_pkg::*;
#(
  parameter longint unsigned CLK_HZ = 50_000_000,
  parameter longint unsigned TMO_NS = 10_000,
  parameter int              AW     = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] cpu_addr,
  input  logic          cpu_wr,
  input  logic [7:0]    cpu_wdata,
  input  logic          cpu_rd,
  output logic [7:0]    cpu_rdata,
  input  logic          epp_mode,
  input  logic          epp_start,
  input  logic          epp_rsp,
  output logic [7:0]    pd_out,
  output logic          pd_oe,
  input  logic [7:0]    pd_in,
  output logic          strobe_n,
  output logic          autofd_n,
  output logic          init_n,
  output logic          selin_n,
  input  logic          busy,
  input  logic          ack_n,
  input  logic          pe,
  input  logic          slct,
  input  logic          err_n
);
  localparam int unsigned TMO_LIMIT = tmo_cycles(CLK_HZ, TMO_NS);

  logic [7:0] data_q;
  logic [5:0] ctrl_q;
  logic [7:0] snap_q;
  pin_stat_t  pins_s;
  logic       rsp_s;
  logic       tmo_flag, tmo_hit;

  // Named access events.
  logic sel_data, sel_stat, sel_ctrl, sel_oor;
  logic wr_data, wr_ctrl, wr_oor, tmo_clr;

  assign sel_data = (cpu_addr == AW'(OFS_DATA));
  assign sel_stat = (cpu_addr == AW'(OFS_STAT));
  assign sel_ctrl = (cpu_addr == AW'(OFS_CTRL));
  assign sel_oor  = !(sel_data || sel_stat || sel_ctrl);
  assign wr_data  = cpu_wr && sel_data;
  assign wr_ctrl  = cpu_wr && sel_ctrl;
  assign wr_oor   = cpu_wr && sel_oor;
  assign tmo_clr  = cpu_wr && sel_stat && cpu_wdata[0];

  pport_sync #(.W(6)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({busy, ack_n, pe, slct, err_n, epp_rsp}),
    .q     ({pins_s, rsp_s})
  );

  pport_tmo #(.LIMIT(TMO_LIMIT)) u_tmo (
    .clk    (clk),
    .rst_n  (rst_n),
    .enable (epp_mode),
    .start  (epp_start),
    .rsp    (rsp_s),
    .clr    (tmo_clr),
    .flag   (tmo_flag),
    .hit    (tmo_hit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      ctrl_q <= '0;
    end else begin
      if (wr_data) data_q <= cpu_wdata;
      if (wr_ctrl) ctrl_q <= cpu_wdata[5:0];
    end
  end

  // Status snapshot tracks the pins except during a read cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       snap_q <= '0;
    else if (!cpu_rd) snap_q <= pack_status(pins_s, tmo_flag);
  end

  always_comb begin
    cpu_rdata = 8'h00;
    if (sel_data)      cpu_rdata = epp_mode ? data_q : pd_in;
    else if (sel_stat) cpu_rdata = snap_q;
    else if (sel_ctrl) cpu_rdata = {2'b00, ctrl_q};
  end

  assign pd_out   = data_q;
  assign pd_oe    = ~ctrl_q[5];
  assign strobe_n = ~ctrl_q[0];
  assign autofd_n = ~ctrl_q[1];
  assign init_n   =  ctrl_q[2];
  assign selin_n  = ~ctrl_q[3];

  assert_data_wr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_data |=> (pd_out == $past(cpu_wdata)));
  assert_ctrl_pins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl |=> (strobe_n == !$past(cpu_wdata[0]) &&
                 autofd_n == !$past(cpu_wdata[1]) &&
                 init_n   ==  $past(cpu_wdata[2]) &&
                 selin_n  == !$past(cpu_wdata[3])));
  assert_dir_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl |=> (pd_oe == !$past(cpu_wdata[5])));
  assert_freeze_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rd |=> $stable(snap_q));
  assert_oor_wr_R11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_oor |=> ($stable(pd_out) && $stable(strobe_n) && $stable(pd_oe)));
  assert_stat_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sel_stat |-> (cpu_rdata[2:1] == 2'b00));
  assert_ctrl_hi_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sel_ctrl |-> (cpu_rdata[7:6] == 2'b00));
endmodule

// File: tb/sim_pport_regs.sv
module sim_pport_regs;
  logic       clk = 0, rst_n = 0;
  logic [2:0] cpu_addr = 0;
  logic       cpu_wr = 0, cpu_rd = 0;
  logic [7:0] cpu_wdata = 0, cpu_rdata, pd_out, pd_in = 0;
  logic       epp_mode = 0, epp_start = 0, epp_rsp = 0, pd_oe;
  logic       strobe_n, autofd_n, init_n, selin_n;
  logic       busy = 0, ack_n = 1, pe = 0, slct = 1, err_n = 1;
  int         n_chk = 0, n_bad = 0;
  logic [7:0] m_data = 0, m_ctrl = 0, rv;
  logic       m_flag = 0;

  localparam int LIM = 50 * 10;  // 50 clocks per us, 10 us window

  always #10 clk = ~clk;

  pport_regs u0 (.*);

  function automatic logic [7:0] exp_stat(logic f);
    logic [7:0] s;
    s = 8'h00;
    s[7] = !busy; s[6] = ack_n; s[5] = pe; s[4] = slct; s[3] = err_n; s[0] = f;
    return s;
  endfunction

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    cpu_addr = a; cpu_wdata = d; cpu_wr = 1;
    @(negedge clk); cpu_wr = 0;
    if (a == 0) m_data = d;
    if (a == 2) m_ctrl = {2'b00, d[5:0]};
    if (a == 1 && d[0]) m_flag = 0;
  endtask

  task automatic rd(logic [2:0] a, output logic [7:0] v);
    cpu_addr = a; cpu_rd = 1; #1 v = cpu_rdata;
    @(negedge clk); cpu_rd = 0;
  endtask

  task automatic chk_pins(string tag);
    chk(tag, pd_out, m_data);
    chk(tag, {3'b0, pd_oe, selin_n, init_n, autofd_n, strobe_n},
        {3'b0, !m_ctrl[5], !m_ctrl[3], m_ctrl[2], !m_ctrl[1], !m_ctrl[0]});
  endtask

  task automatic epp_timeout_case(string tag, logic mode, int rsp_at, logic exp_f);
    epp_mode = mode;
    epp_start = 1; @(negedge clk); epp_start = 0;
    if (rsp_at > 0) begin
      cyc(rsp_at); epp_rsp = 1; cyc(4); epp_rsp = 0;
    end
    cyc(LIM + 10);
    rd(1, rv); chk(tag, rv[0], exp_f);
  endtask

  initial begin
    void'($urandom(1234));
    cyc(3); rst_n = 1; cyc(5);
    chk_pins("R1 reset pins");
    rd(1, rv); chk("R1 reset flag", rv[0], 0);

    wr(0, 8'hA5); chk_pins("R2 data");
    epp_mode = 1; rd(0, rv); chk("R3 epp data read", rv, 8'hA5);
    epp_mode = 0; pd_in = 8'h3C; rd(0, rv); chk("R3 spp pin read", rv, 8'h3C);
    wr(2, 8'hFF); rd(2, rv); chk("R6 ctrl read", rv, 8'h3F); chk_pins("R7 R8 pins");
    wr(2, 8'h15); chk_pins("R7 pins");

    busy = 1; ack_n = 0; pe = 1; slct = 0; err_n = 0; cyc(4);
    rd(1, rv); chk("R4 status", rv, exp_stat(0));
    // freeze during read
    cpu_addr = 1; cpu_rd = 1; cyc(1);
    busy = 0; ack_n = 1; cyc(5); #1 rv = cpu_rdata;
    chk("R5 frozen", rv, 8'h00 | {1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 3'b000});
    cpu_rd = 0; cyc(4);
    rd(1, rv); chk("R5 released", rv, exp_stat(0));

    wr(5, 8'h77); wr(3, 8'h01); chk_pins("R11 oor write ignored");
    rd(6, rv); chk("R11 oor read", rv, 0);

    epp_timeout_case("R12 spp no timeout", 0, 0, 0);
    epp_mode = 1; epp_start = 1; @(negedge clk); epp_start = 0;
    cyc(LIM - 3); rd(1, rv); chk("R9 before limit", rv[0], 0);
    cyc(6); rd(1, rv); chk("R9 after limit", rv[0], 1); m_flag = 1;
    wr(1, 8'hFE); cyc(2); rd(1, rv); chk("R10 write 0 keeps", rv[0], 1);
    wr(1, 8'h01); cyc(2); rd(1, rv); chk("R10 write 1 clears", rv[0], 0);
    epp_timeout_case("R9 response stops", 1, 100, 0);
    epp_mode = 0;

    for (int i = 0; i < 60; i++) begin
      logic [2:0] a;
      logic [7:0] d;
      a = 3'($urandom_range(0, 7)); d = 8'($urandom);
      case ($urandom_range(0, 2))
        0: begin wr(a, d); chk_pins("R2 R7 R11 random write"); end
        1: begin
          epp_mode = 1'($urandom); pd_in = 8'($urandom); rd(a, rv);
          case (a)
            0: chk("R3 random", rv, epp_mode ? m_data : pd_in);
            1: chk("R4 random", rv, exp_stat(m_flag));
            2: chk("R6 random", rv, m_ctrl);
            default: chk("R11 random", rv, 0);
          endcase
          epp_mode = 0;
        end
        default: begin
          {busy, ack_n, pe, slct, err_n} = 5'($urandom); cyc(4);
          rd(1, rv); chk("R4 random status", rv, exp_stat(m_flag));
        end
      endcase
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #3_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule